// File: doc/BRIEF.md
# Indexed CPU Clock Selector with Pulse-Swallow Throttle

This block derives two single-cycle clock-enable strobes, one for a CPU core and one for its L2 cache, from a fast reference clock. A 4-bit base register picks one of sixteen rate entries. Each entry maps to a number of reference cycles per base slot, so the entries correspond to nominal core rates of 42, 83, 111, 125, 166, 222, 250, 333, 444 and 500 MHz when the reference runs near 4 GHz. A second register throttles the chosen rate in sixteenths by suppressing ("swallowing") base slots.

Base slots are grouped into windows of sixteen. In each window exactly `a` slots are swallowed, where `a` is the effective adjust value. An accumulator spreads the swallowed slots evenly across the window. Register writes take effect only at the next window boundary, so no window ever mixes two settings. The L2 strobe is always a subset of the core strobe. Three entries run the L2 at half the core rate.

A simple write/read port reaches the two registers. Both registers read back the raw value last written.

Top module: `cpu_clk_throttle`

## Requirements
- R1: While in reset and after reset, base reads 1 and adjust reads 0. No strobe appears before the first base slot completes.
- R2: Each base slot lasts a fixed number of reference cycles, set by the base index: 1→96, 3→48, 4→36, 5→24, 6→18, 7→12, 8→9, 9→8, 10→12, 12→32, 13→16, 14→9, 15→8. Each delivered slot produces one core strobe.
- R3: Base indices 0, 2 and 11 behave exactly like index 1 (96 cycles per slot).
- R4: For base indices 8, 9 and 10, the L2 strobe fires on every second delivered core strobe of a window, giving floor(n/2) L2 strobes for n delivered slots. For all other indices it fires with every core strobe.
- R5: With effective adjust a (0..8), exactly a of every 16 consecutive base slots give no core strobe, so the core rate is the base rate times (1 - a/16).
- R6: An adjust value of 9 or more is treated as 0.
- R7: Swallowed slots are spread evenly. In slot k (1..16) of a window, the slot is swallowed iff floor(k·a/16) > floor((k-1)·a/16). Two consecutive core strobes are therefore always div or 2·div reference cycles apart.
- R8: A register write changes the strobe pattern only after the 16th slot of the current window.
- R9: Register address 0 is the base register and address 1 is the adjust register. A write stores wr_data[3:0] and ignores the upper bits. A read returns the stored 4-bit value zero-extended and unclamped.
- R10: l2_en is never high in a cycle where core_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 base, 1 adjust |
| wr_data | input | 8 | Write data; bits 3:0 used |
| rd_addr | input | 1 | Read select: 0 base, 1 adjust |
| rd_data | output | 8 | Read data, zero-extended register value |
| core_en | output | 1 | Core clock-enable strobe |
| l2_en | output | 1 | L2 cache clock-enable strobe |

## Verification
The bench targets the fallback indices 0, 2 and 11. A design that decoded them to their own rates would show a slot length other than 96 cycles. It also drives adjust values 9 and 12, where a design that failed to clamp would swallow the wrong number of slots, and the half-rate L2 entries, where a wrong phase rule gives the wrong L2 count per window. It writes a new base index just after the first strobe of a window and expects fifteen more old-rate intervals before the change. An early switch shortens that run. Each run also checks that strobe spacing is one or two slots, which a bunched swallow pattern breaks.

// File: rtl/cts_pkg.sv
package cts_pkg;

  localparam int unsigned BASE_W     = 4;
  localparam int unsigned ADJ_W      = 4;
  localparam int unsigned RATE_DIV_W = 7;

  // Reference cycles per base slot, keyed by base index.
  function automatic logic [RATE_DIV_W-1:0] slot_len(input logic [BASE_W-1:0] idx);
    logic [RATE_DIV_W-1:0] d;
    case (idx)
      4'd3:    d = 7'd48;
      4'd4:    d = 7'd36;
      4'd5:    d = 7'd24;
      4'd6:    d = 7'd18;
      4'd7:    d = 7'd12;
      4'd8:    d = 7'd9;
      4'd9:    d = 7'd8;
      4'd10:   d = 7'd12;
      4'd12:   d = 7'd32;
      4'd13:   d = 7'd16;
      4'd14:   d = 7'd9;
      4'd15:   d = 7'd8;
      default: d = 7'd96;   // 1 and the undefined 0, 2, 11
    endcase
    return d;
  endfunction

  function automatic logic l2_is_half(input logic [BASE_W-1:0] idx);
    return (idx == 4'd8) || (idx == 4'd9) || (idx == 4'd10);
  endfunction

endpackage

// File: rtl/cts_regs.sv
module cts_regs #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BASE_W     = 4,
  parameter int unsigned ADJ_W      = 4,
  parameter int unsigned RESET_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [BASE_W-1:0] base_q,
  output logic [ADJ_W-1:0]  adj_q
);

  logic              base_we, adj_we;
  logic [BASE_W-1:0] base_d;
  logic [ADJ_W-1:0]  adj_d;

  always_comb begin
    base_we = wr_en && !wr_addr;
    adj_we  = wr_en &&  wr_addr;
    base_d  = wr_data[BASE_W-1:0];
    adj_d   = wr_data[ADJ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_W'(RESET_BASE);
      adj_q  <= '0;
    end else begin
      if (base_we) base_q <= base_d;
      if (adj_we)  adj_q  <= adj_d;
    end
  end

  always_comb begin
    if (rd_addr) rd_data = {{(DATA_W-ADJ_W){1'b0}}, adj_q};
    else         rd_data = {{(DATA_W-BASE_W){1'b0}}, base_q};
  end

  // R9
  base_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> (base_q == $past(wr_data[BASE_W-1:0])));

  // R9
  adj_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> (adj_q == $past(wr_data[ADJ_W-1:0])));

endmodule

// File: rtl/cts_rate_rom.sv
module cts_rate_rom #(
  parameter int unsigned BASE_W = 4,
  parameter int unsigned DIV_W  = 7
) (
  input  logic [BASE_W-1:0] idx,
  output logic [DIV_W-1:0]  div,
  output logic              l2_half
);
  import cts_pkg::*;

  always_comb begin
    div     = DIV_W'(slot_len(idx));
    l2_half = l2_is_half(idx);
  end

  // R2
  rom_nonzero_chk: assert final (DIV_W >= RATE_DIV_W);

endmodule

// File: rtl/cts_pacer.sv
module cts_pacer #(
  parameter int unsigned BASE_W     = 4,
  parameter int unsigned ADJ_W      = 4,
  parameter int unsigned DIV_W      = 7,
  parameter int unsigned WIN_W      = 4,
  parameter int unsigned ADJ_MAX    = 8,
  parameter int unsigned RESET_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] base_req,
  input  logic [ADJ_W-1:0]  adj_req,
  output logic              core_en,
  output logic              l2_en
);

  localparam int unsigned SLOTS = 1 << WIN_W;
  localparam int unsigned ACC_W = WIN_W + 1;

  logic [BASE_W-1:0] act_base_q, act_base_d;
  logic [ADJ_W-1:0]  act_adj_q, act_adj_d, adj_clamped;
  logic [DIV_W-1:0]  cnt_q, cnt_d, div_act;
  logic [WIN_W-1:0]  pos_q, pos_d;
  logic [ACC_W-1:0]  acc_q, acc_d, acc_sum;
  logic              phase_q, phase_d;
  logic              prev_sw_q, prev_sw_d;
  logic              core_q, core_d, l2_q, l2_d;
  logic              half_act, slot_hit, boundary, swallow, deliver;

  cts_rate_rom #(.BASE_W(BASE_W), .DIV_W(DIV_W)) i_rom (
    .idx     (act_base_q),
    .div     (div_act),
    .l2_half (half_act)
  );

  // next-state logic
  always_comb begin
    slot_hit    = (cnt_q == (div_act - DIV_W'(1)));
    cnt_d       = slot_hit ? '0 : cnt_q + DIV_W'(1);
    boundary    = slot_hit && (pos_q == {WIN_W{1'b1}});
    pos_d       = slot_hit ? pos_q + WIN_W'(1) : pos_q;
    acc_sum     = acc_q + ACC_W'(act_adj_q);
    swallow     = slot_hit && (acc_sum >= ACC_W'(SLOTS));
    if (!slot_hit)    acc_d = acc_q;
    else if (swallow) acc_d = acc_sum - ACC_W'(SLOTS);
    else              acc_d = acc_sum;
    deliver     = slot_hit && !swallow;
    core_d      = deliver;
    l2_d        = deliver && (!half_act || phase_q);
    if (boundary)     phase_d = 1'b0;
    else if (deliver) phase_d = ~phase_q;
    else              phase_d = phase_q;
    prev_sw_d   = slot_hit ? swallow : prev_sw_q;
    adj_clamped = (adj_req > ADJ_W'(ADJ_MAX)) ? '0 : adj_req;
    act_base_d  = boundary ? base_req    : act_base_q;
    act_adj_d   = boundary ? adj_clamped : act_adj_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      pos_q      <= '0;
      acc_q      <= '0;
      phase_q    <= 1'b0;
      prev_sw_q  <= 1'b0;
      core_q     <= 1'b0;
      l2_q       <= 1'b0;
      act_base_q <= BASE_W'(RESET_BASE);
      act_adj_q  <= '0;
    end else begin
      cnt_q     <= cnt_d;
      core_q    <= core_d;
      l2_q      <= l2_d;
      if (slot_hit) begin
        pos_q     <= pos_d;
        acc_q     <= acc_d;
        phase_q   <= phase_d;
        prev_sw_q <= prev_sw_d;
      end
      if (boundary) begin
        act_base_q <= act_base_d;
        act_adj_q  <= act_adj_d;
      end
    end
  end

  assign core_en = core_q;
  assign l2_en   = l2_q;

  // R10
  l2_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_q |-> core_q);

  // R6
  adj_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_adj_q <= ADJ_W'(ADJ_MAX));

  // R8
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_base_q) && $stable(act_adj_q)));

  // R5
  acc_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (acc_q == '0));

  // R7
  no_double_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swallow |-> !prev_sw_q);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_act);

endmodule

// File: rtl/cpu_clk_throttle.sv
module cpu_clk_throttle #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DIV_W      = 7,
  parameter int unsigned WIN_W      = 4,
  parameter int unsigned ADJ_MAX    = 8,
  parameter int unsigned RESET_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              core_en,
  output logic              l2_en
);
  import cts_pkg::*;

  logic              rst_meta_q, rst_sync_n;
  logic [BASE_W-1:0] base_q;
  logic [ADJ_W-1:0]  adj_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cts_regs #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .ADJ_W(ADJ_W), .RESET_BASE(RESET_BASE)
  ) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .base_q(base_q), .adj_q(adj_q)
  );

  cts_pacer #(
    .BASE_W(BASE_W), .ADJ_W(ADJ_W), .DIV_W(DIV_W), .WIN_W(WIN_W),
    .ADJ_MAX(ADJ_MAX), .RESET_BASE(RESET_BASE)
  ) i_pacer (
    .clk(clk), .rst_n(rst_sync_n), .base_req(base_q), .adj_req(adj_q),
    .core_en(core_en), .l2_en(l2_en)
  );

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_sync_n |=> !core_en);

endmodule

// File: tb/test_cpu_clk_throttle.sv
module test_cpu_clk_throttle;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       core_en, l2_en;

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;

  typedef struct {
    int    div;
    int    core_n;
    int    l2_n;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  cpu_clk_throttle i_cpu_clk_throttle (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .core_en(core_en), .l2_en(l2_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slot length from the R2/R3 table
  function automatic int exp_div(input int b);
    case (b)
      3: return 48;  4: return 36;  5: return 24;  6: return 18;
      7: return 12;  8: return 9;   9: return 8;   10: return 12;
      12: return 32; 13: return 16; 14: return 9;  15: return 8;
      default: return 96;
    endcase
  endfunction

  task automatic reg_write(input bit addr, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input bit addr, output int val);
    @(negedge clk);
    rd_addr = addr;
    #1 val = int'(rd_data);
  endtask

  // driver: program, push expectation, wait for the monitor
  task automatic run(input int base, input int adj, input string tag);
    exp_t e;
    int a, start;
    a = (adj > 8) ? 0 : adj;
    e.div = exp_div(base);
    e.core_n = 16 - a;
    e.l2_n = (base == 8 || base == 9 || base == 10) ? (16 - a) / 2 : 16 - a;
    e.tag = tag;
    reg_write(1'b0, base);
    reg_write(1'b1, adj);
    start = done_cnt;
    sb_q.push_back(e);
    wait (done_cnt != start);
  endtask

  // monitor: settle, then measure 16 slots
  initial begin : monitor
    forever begin
      exp_t e;
      int nc, nl, last, bad_gap, stray;
      wait (sb_q.size() != 0);
      e = sb_q.pop_front();
      repeat (1700) @(negedge clk);
      while (!core_en) @(negedge clk);
      nc = 0; nl = 0; last = 0; bad_gap = 0; stray = 0;
      for (int t = 1; t <= 16 * e.div; t++) begin
        @(negedge clk);
        if (l2_en && !core_en) stray++;
        if (core_en) begin
          nc++;
          if ((t - last) != e.div && (t - last) != 2 * e.div) bad_gap = t - last;
          last = t;
        end
        if (l2_en) nl++;
      end
      check(nc == e.core_n, {"R2/R5 core count ", e.tag}, nc, e.core_n);
      check(nl == e.l2_n, {"R4 l2 count ", e.tag}, nl, e.l2_n);
      check(bad_gap == 0, {"R7 spacing ", e.tag}, bad_gap, e.div);
      check(stray == 0, {"R10 subset ", e.tag}, stray, 0);
      done_cnt++;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    int v, gap, t, n96;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(core_en == 1'b0, "R1 no strobe in reset", int'(core_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(1'b0, v); check(v == 1, "R1 base reset", v, 1);
    reg_read(1'b1, v); check(v == 0, "R1 adj reset", v, 0);

    // R8: first strobe of the first window, then change the base
    while (!core_en) @(negedge clk);
    reg_write(1'b0, 15);
    t = 2; n96 = 0; gap = 0;
    while (gap != 8 && n96 < 40) begin
      @(negedge clk); t++;
      if (core_en) begin
        gap = t;
        if (gap == 96) n96++;
        t = 0;
      end
    end
    check(n96 == 15, "R8 old rate held to window end", n96, 15);
    check(gap == 8, "R8 new rate after boundary", gap, 8);

    // R9: readback, upper bits dropped, unclamped adjust
    reg_write(1'b1, 8'hFC);
    reg_read(1'b1, v); check(v == 12, "R9 adj readback", v, 12);
    reg_write(1'b0, 8'hA7);
    reg_read(1'b0, v); check(v == 7, "R9 base readback", v, 7);

    run(7, 0, "b7a0");
    run(9, 0, "b9a0");
    run(15, 8, "b15a8");
    run(4, 3, "b4a3");
    run(10, 5, "b10a5");
    run(8, 1, "b8a1");
    run(13, 7, "b13a7");
    run(0, 0, "R3 b0");
    run(2, 2, "R3 b2");
    run(11, 0, "R3 b11");
    run(12, 12, "R6 adj12");
    run(6, 9, "R6 adj9");
    reg_read(1'b1, v); check(v == 9, "R9 adj9 readback", v, 9);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule